// File: doc/BRIEF.md
# Converter Stop-Mode Access Controller

This block sits between a simple register bus and the control side of an analog-to-digital converter peripheral. It decides what happens when software sets the stop bit. While stop is held, it gates off the converter clock, holds the periodic timer in reset and aborts any conversion sequence that is running. It also gives each register group its own access rule. When stop is cleared, it runs a recovery countdown before it reports the converter ready. Conversion triggers that arrive before ready are dropped.

The register space has two halves, split by the top address bit. The upper half is the result/command memory. The lower half holds ten control and status registers in three policy groups, and the rest of the lower half is unmapped. Every access finishes in one cycle: read data and the error flag follow the address in the same cycle, and writes land at the next clock edge. The bus logic keeps running in every mode. The converter itself is reduced to a busy input.

Top module: `cnv_stop_guard`

## Requirements
- R1: In the cycle after the clock edge that samples `stop_req` high, `conv_clk_en` is 0, `timer_hold` is 1 and `ready` is 0, and they stay that way as long as `stop_req` stays high.
- R2: `seq_abort` is high for exactly one cycle after the edge at which stop is entered, and only if `busy_in` was high at that edge. Otherwise it stays low.
- R3: Addresses 0 to 2 (the open group) can be read and written in every mode and keep their contents across stop.
- R4: Addresses 3 to 5 (the kept group) stay readable during stop. Writes to them during stop are ignored and their contents are kept.
- R5: Addresses 6 to 9 (the wiped group) read 0 from the edge that enters stop onward. Writes to them during stop are ignored.
- R6: Memory addresses 16 to 31 (bit 4 set) read 0 with `bus_err` = 1 during stop, and writes to them are ignored. Their contents are unchanged when stop is left.
- R7: After the first edge that samples `stop_req` low while stopped, `ready` stays 0 for exactly RECOVERY_CYCLES cycles (default 64) and then rises. `conv_clk_en` is 1 during recovery.
- R8: `conv_start` equals `trig_in` while `ready` is 1, and is 0 otherwise, so a trigger during stop or recovery is dropped.
- R9: Setting `stop_req` again during recovery re-enters stop completely: the wiped group is cleared again and the full recovery count starts over when stop is next cleared.
- R10: After reset, `ready` = 1, `conv_clk_en` = 1, `timer_hold` = 0, `seq_abort` = 0, and every register and memory word reads 0.
- R11: Outside stop, every register and memory word can be written and read back, and `bus_err` stays 0. Unmapped addresses 10 to 15 always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | Software stop bit |
| busy_in | input | 1 | Conversion sequence in progress |
| trig_in | input | 1 | Conversion trigger request |
| bus_valid | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, same cycle |
| bus_err | output | 1 | Access refused (memory during stop) |
| conv_clk_en | output | 1 | Converter clock enable |
| seq_abort | output | 1 | One-cycle sequence abort |
| timer_hold | output | 1 | Periodic timer held in reset |
| ready | output | 1 | Converter ready for conversions |
| conv_start | output | 1 | Accepted conversion trigger |

## Verification
The bench enters stop both with and without a busy converter. A design with an unqualified or stretched abort would pulse when idle or hold the pulse for two cycles. During stop it sends random writes to every address and reads the whole map back. A wrong group policy shows up there: a kept register that changes, a wiped register that holds an old value, or memory that answers without the error flag. The recovery window is checked at both its last low cycle and its first ready cycle, so an off-by-one in the countdown is caught. Stop is also re-armed partway through recovery, which catches a design that skips the second clear or resumes the old count.

// File: rtl/cnv_stop_pkg.sv
// Shared types for the stop-mode access controller.
// Assumes ten control/status registers in the lower address half.
package cnv_stop_pkg;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_HALT = 2'd1,
        PH_WARM = 2'd2
    } phase_t;

    typedef enum logic [2:0] {
        GRP_OPEN = 3'd0,
        GRP_KEEP = 3'd1,
        GRP_WIPE = 3'd2,
        GRP_MEM  = 3'd3,
        GRP_NONE = 3'd4
    } grp_t;

    localparam int NUM_REGS = 10;

    // Maps a word address to its stop-mode policy group.
    function automatic grp_t classify(input int unsigned a, input int unsigned mem_base);
        if (a >= mem_base)  return GRP_MEM;
        else if (a < 3)     return GRP_OPEN;
        else if (a < 6)     return GRP_KEEP;
        else if (a < 10)    return GRP_WIPE;
        else                return GRP_NONE;
    endfunction

endpackage

// File: rtl/stop_seq.sv
// Stop sequencer: tracks run / halted / warming phases and the recovery count.
// Assumes RECOVERY_CYCLES >= 1. enter_o is combinational and marks the
// edge at which stop is taken.
module stop_seq
    import cnv_stop_pkg::*;
#(
    parameter int RECOVERY_CYCLES = 64
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stop_req,
    input  logic   busy_in,
    output phase_t phase_o,
    output logic   enter_o,
    output logic   abort_o
);
    localparam int CNT_W = $clog2(RECOVERY_CYCLES + 1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    // Stop is taken whenever the bit is sampled high outside the halted phase.
    assign enter_o = stop_req && (phase != PH_HALT);
    assign phase_o = phase;

    // Phase transitions, recovery countdown and the registered abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_RUN;
            cnt     <= '0;
            abort_o <= 1'b0;
        end else begin
            abort_o <= enter_o && busy_in;
            case (phase)
                PH_HALT: begin
                    if (!stop_req) begin
                        phase <= PH_WARM;
                        cnt   <= CNT_W'(RECOVERY_CYCLES);
                    end
                end
                PH_WARM: begin
                    if (stop_req)       phase <= PH_HALT;
                    else if (cnt <= 1)  phase <= PH_RUN;
                    else                cnt   <= cnt - 1'b1;
                end
                default: begin
                    if (stop_req) phase <= PH_HALT;
                end
            endcase
        end
    end

    assert_abort_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

endmodule

// File: rtl/reg_bank.sv
// Control/status register bank with a per-group stop-mode write policy.
// Assumes idx addresses registers 0..NUM_REGS-1; other indices read zero
// and drop writes. Reads are combinational.
module reg_bank
    import cnv_stop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halted,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam grp_t GRP = classify(g, 1 << IDX_W);
        localparam bit   WRITABLE_IN_HALT = (GRP == GRP_OPEN);

        // One register: clear on stop entry for the wiped group, else gated write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g] <= '0;
            else if (clear && GRP == GRP_WIPE)
                q[g] <= '0;
            else if (wr_en && idx == IDX_W'(g) && (!halted || WRITABLE_IN_HALT))
                q[g] <= wdata;
        end

        if (GRP == GRP_KEEP) begin : g_keep_chk
            assert_keep_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
                halted |=> $stable(q[g]));
        end
        if (GRP == GRP_WIPE) begin : g_wipe_chk
            assert_wipe_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (clear || halted) |=> (q[g] == '0));
        end
    end

    // Read mux, zero for unmapped indices.
    always_comb begin
        rdata = '0;
        if (int'(idx) < NUM_REGS) rdata = q[idx];
    end

endmodule

// File: rtl/mem_store.sv
// Result/command word store. While halted it keeps its contents, drops
// writes and reads zero. Assumes the caller gates writes to its own range.
module mem_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     halted,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        // One word: cleared by reset, written only outside stop.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (wr_en && !halted && idx == $clog2(DEPTH)'(i))
                mem[i] <= wdata;
        end

        assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            halted |=> $stable(mem[i]));
    end

    // Read path blanked while stopped.
    assign rdata = halted ? '0 : mem[idx];

endmodule

// File: rtl/cnv_stop_guard.sv
// Top: stop-mode access controller. It combines the stop sequencer, the
// register bank and the memory store, and decodes the bus. Accesses finish
// in one cycle; the bus side never stalls.
module cnv_stop_guard
    import cnv_stop_pkg::*;
#(
    parameter int DATA_W          = 16,
    parameter int ADDR_W          = 5,
    parameter int RECOVERY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              busy_in,
    input  logic              trig_in,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              conv_clk_en,
    output logic              seq_abort,
    output logic              timer_hold,
    output logic              ready,
    output logic              conv_start
);
    localparam int IDX_W     = ADDR_W - 1;
    localparam int MEM_DEPTH = 1 << IDX_W;

    phase_t            phase;
    logic              enter;
    logic              halted;
    grp_t              grp;
    logic [DATA_W-1:0] reg_rd;
    logic [DATA_W-1:0] mem_rd;

    stop_seq #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .busy_in(busy_in),
        .phase_o(phase), .enter_o(enter), .abort_o(seq_abort)
    );

    reg_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .halted(halted), .clear(enter),
        .wr_en(bus_valid && bus_we && !bus_addr[ADDR_W-1]),
        .idx(bus_addr[IDX_W-1:0]), .wdata(bus_wdata), .rdata(reg_rd)
    );

    mem_store #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .halted(halted),
        .wr_en(bus_valid && bus_we && bus_addr[ADDR_W-1]),
        .idx(bus_addr[IDX_W-1:0]), .wdata(bus_wdata), .rdata(mem_rd)
    );

    // Mode outputs derived from the sequencer phase.
    assign halted      = (phase == PH_HALT);
    assign conv_clk_en = !halted;
    assign timer_hold  = halted;
    assign ready       = (phase == PH_RUN);
    assign conv_start  = trig_in && ready;

    // Address decode, read mux and the refusal flag.
    always_comb begin
        grp     = classify(int'(bus_addr), MEM_DEPTH);
        bus_err = bus_valid && halted && (grp == GRP_MEM);
        case (grp)
            GRP_MEM:  bus_rdata = mem_rd;
            GRP_NONE: bus_rdata = '0;
            default:  bus_rdata = reg_rd;
        endcase
    end

    assert_halt_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stop_req)) |-> (!conv_clk_en && timer_hold && !ready));
    assert_ready_after_warm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(ready)) |-> !$past(stop_req));
    assert_start_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_clk_en && !timer_hold));
    assert_err_only_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (timer_hold && bus_rdata == '0));

endmodule

// File: tb/cnv_stop_guard_test.sv
module cnv_stop_guard_test;
    localparam int DW = 16;
    localparam int AW = 5;
    localparam int NREC = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, busy_in = 0, trig_in = 0, bus_valid = 0, bus_we = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic bus_err, conv_clk_en, seq_abort, timer_hold, ready, conv_start;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] shadow [32];
    bit halted_m = 0;

    always #2 clk = ~clk;

    cnv_stop_guard #(.DATA_W(DW), .ADDR_W(AW), .RECOVERY_CYCLES(NREC)) uut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .busy_in(busy_in),
        .trig_in(trig_in), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .conv_clk_en(conv_clk_en), .seq_abort(seq_abort),
        .timer_hold(timer_hold), .ready(ready), .conv_start(conv_start)
    );

    // Policy group by address: 0 open, 1 kept, 2 wiped, 3 memory, 4 unmapped.
    function automatic int grp_of(input int a);
        if (a >= 16) return 3;
        if (a < 3)   return 0;
        if (a < 6)   return 1;
        if (a < 10)  return 2;
        return 4;
    endfunction

    function automatic bit write_lands(input int a, input bit halted);
        int g = grp_of(a);
        if (g == 4) return 0;
        if (g == 0) return 1;
        return !halted;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_valid = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
        if (write_lands(a, halted_m)) shadow[a] = d;
        @(negedge clk);
        bus_valid = 0; bus_we = 0;
    endtask

    task automatic do_read(input string req, input int a);
        logic exp_err;
        @(negedge clk);
        bus_valid = 1; bus_we = 0; bus_addr = AW'(a);
        #1;
        exp_err = halted_m && grp_of(a) == 3;
        check(req, {15'd0, bus_err, bus_rdata}, {15'd0, exp_err, (exp_err ? 16'h0 : shadow[a])});
        bus_valid = 0;
    endtask

    task automatic enter_stop(input string req, input logic busy);
        @(negedge clk);
        stop_req = 1; busy_in = busy;
        @(negedge clk);
        halted_m = 1;
        for (int a = 6; a < 10; a++) shadow[a] = '0;
        check({req, " R2 abort"}, seq_abort, busy);
        check({req, " R1 outputs"}, {conv_clk_en, timer_hold, ready}, 3'b010);
        busy_in = 0;
        @(negedge clk);
        check({req, " R2 single"}, seq_abort, 0);
        check({req, " R1 held"}, {conv_clk_en, timer_hold, ready}, 3'b010);
    endtask

    task automatic leave_stop(input string req);
        @(negedge clk);
        stop_req = 0;
        halted_m = 0;
        for (int i = 1; i <= NREC; i++) begin
            @(negedge clk);
            if (i == 1) begin
                check({req, " R7 clk_en"}, {conv_clk_en, timer_hold}, 2'b10);
                trig_in = 1; #1;
                check({req, " R8 trig dropped"}, conv_start, 0);
                trig_in = 0;
            end
            if (i == NREC) check({req, " R7 last low"}, ready, 0);
        end
        @(negedge clk);
        check({req, " R7 ready"}, ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234abcd));
        for (int a = 0; a < 32; a++) shadow[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        check("R10 mode", {ready, conv_clk_en, timer_hold, seq_abort}, 4'b1100);
        for (int a = 0; a < 32; a += 5) do_read("R10 zero", a);

        // R11: normal-mode random writes, then full readback
        for (int n = 0; n < 60; n++) do_write(int'($urandom_range(31, 0)), DW'($urandom));
        do_write(12, 16'hbeef);
        for (int a = 0; a < 32; a++) do_read("R11 readback", a);
        trig_in = 1; #1;
        check("R8 trig accepted", conv_start, 1);
        trig_in = 0;

        // Stop with a busy converter
        enter_stop("busy", 1);
        trig_in = 1; #1;
        check("R8 trig in stop", conv_start, 0);
        trig_in = 0;
        for (int n = 0; n < 50; n++) do_write(int'($urandom_range(31, 0)), DW'($urandom));
        for (int a = 0; a < 3; a++) do_write(a, DW'(16'h0a00 + a));
        do_write(4, 16'h5555);
        do_write(7, 16'h7777);
        do_write(20, 16'h2020);
        for (int a = 0; a < 3; a++) do_read("R3 open", a);
        for (int a = 3; a < 6; a++) do_read("R4 kept", a);
        for (int a = 6; a < 10; a++) do_read("R5 wiped", a);
        for (int a = 16; a < 32; a++) do_read("R6 memory refused", a);
        check("R1 still held", {conv_clk_en, timer_hold, ready}, 3'b010);

        leave_stop("first");
        for (int a = 0; a < 32; a++) do_read("R6 retained", a);
        trig_in = 1; #1;
        check("R8 trig after ready", conv_start, 1);
        trig_in = 0;

        // Idle stop: no abort; then re-arm during recovery
        enter_stop("idle", 0);
        @(negedge clk);
        stop_req = 0;
        halted_m = 0;
        repeat (10) @(negedge clk);
        check("R9 mid recovery", ready, 0);
        do_write(6, 16'h6666);
        do_write(9, 16'h9999);
        do_read("R9 write in recovery", 6);
        enter_stop("R9 restop", 0);
        do_read("R9 wiped again", 6);
        do_read("R9 wiped again", 9);
        leave_stop("R9 full count");
        do_read("R11 unmapped", 12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule